// File: doc/BRIEF.md
# Counter Channel Clock/Gate Router with Change Interrupt

This block sits in front of a bank of three independent counter channels. For every channel it picks where the counting clock comes from and where the gate level comes from. The counters are clocked by a single-cycle clock-enable. That enable can come from a software strobe, from a 1 MHz timebase tick, from rising edges of an external clock pin, or (for channels 1 and 2 only) from rising edges of channel 0's output. The gate can come from a software-written level or from an external gate pin. Both pins are asynchronous, so they pass through a synchronizer inside the block.

The block also watches the counter outputs. Whenever an enabled channel's output changes level in either direction, a sticky status bit is set. The interrupt line is the OR of the enabled status bits. Software clears a status bit by writing a 1 to its clear position.

Software reaches the block through a plain write port: a write strobe, a 2-bit address and a 6-bit data word. Nothing is read back through that port. The status bits are offered directly as an output vector.

Top module: `ctr_route_irq`

## Requirements
- R1: After reset every channel's clock source is the software strobe (code 0), every gate is software-sourced with level 0, interrupt enables and status are 0, and all of `ctr_ce_o`, `ctr_gate_o`, `irq_o` and `irq_status_o` are 0.
- R2: A write to address 0 loads channel n's 2-bit clock source from data bits [2n+1:2n]. The codes are: 0 = software strobe, 1 = timebase tick, 2 = external clock, 3 = channel 0 output. With code 1, a high `tick_i` sampled at a clock edge gives `ctr_ce_o[n]` high for exactly the following cycle.
- R3: A write to address 2 with data bit n set gives exactly one enable pulse on channel n in the cycle after the write, but only if channel n's source is code 0. It has no effect on channels set to other codes.
- R4: The external clock is synchronized through two flops. A rising edge gives exactly one enable pulse on every channel set to code 2, visible after the third clock edge following the change. A level held high gives no further pulses.
- R5: Channels 1 and 2 set to code 3 get one enable pulse per rising edge of `ctr_out_i[0]`, with the same synchronization and latency as R4.
- R6: Channel 0 set to code 3 never produces an enable pulse.
- R7: A write to address 1 sets, for each channel n, the gate source from data bit n (1 = external pin, 0 = software) and the software gate level from data bit 3+n. `ctr_gate_o` reflects the write one edge later.
- R8: A channel with an external gate source follows `ext_gate_i` through a three-flop path. A change becomes visible after the third clock edge.
- R9: A write to address 3 loads the interrupt enables from data bits [2:0]. A change in either direction of `ctr_out_i[n]` while enable n is set sets `irq_status_o[n]` at the next edge. A change while enable n is clear does not set it.
- R10: A status bit stays set until a write to address 3 has data bit 3+n at 1, which clears it (that same write also reloads the enables). A change detected in the same cycle as the clear wins, and the bit stays set.
- R11: `irq_o` is high exactly when some status bit and its enable are both set. Clearing an enable hides its status bit from `irq_o` without clearing that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 clock source, 1 gate, 2 software strobe, 3 interrupt) |
| wr_data | input | 6 | Write data |
| tick_i | input | 1 | 1 MHz timebase tick, one cycle wide, synchronous |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| ext_gate_i | input | 1 | External gate pin, asynchronous |
| ctr_out_i | input | 3 | Counter channel outputs |
| ctr_ce_o | output | 3 | Per-channel count enable pulses |
| ctr_gate_o | output | 3 | Per-channel gate levels |
| irq_o | output | 1 | Interrupt request |
| irq_status_o | output | 3 | Sticky change status bits |

## Verification
A table of mixed source settings is walked to confirm that each channel follows its own code. A router that shared one select across channels, or let a strobe leak into timebase channels, would emit the wrong enable vector. Directed tests hold the external clock and the channel 0 output high for many cycles and count pulses. An edge detector that passed levels through would emit a train instead of one pulse, and a channel 0 with cascade selected would pick up its own output. The interrupt tests cover a falling change, a change on a disabled channel, a clear that arrives together with a new change, and an enable dropped after a bit was set. A design that let the clear win, or cleared status when the enable was removed, would report the wrong status vector.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_TICK = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_CASC = 2'd3
    } clk_src_e;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CLKSEL = 2'd0;
    localparam logic [ADDR_W-1:0] A_GATE   = 2'd1;
    localparam logic [ADDR_W-1:0] A_STROBE = 2'd2;
    localparam logic [ADDR_W-1:0] A_IRQ    = 2'd3;

endpackage

// File: rtl/ctr_sync.sv
module ctr_sync #(
    parameter int                 WIDTH     = 3,
    parameter int                 STAGES    = 2,
    parameter logic [WIDTH-1:0]   EDGE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] out_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] sync;
        logic [WIDTH-1:0]             last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = din_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        st_d.last    = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_edge
            assign out_o[i] = st_q.sync[STAGES-1][i] & ~st_q.last[i];

            AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                out_o[i] |=> !out_o[i]); // R4
        end else begin : g_level
            assign out_o[i] = st_q.last[i];
        end
    end

endmodule

// File: rtl/ctr_ch_route.sv
module ctr_ch_route
    import ctr_route_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_we_i,
    input  logic [1:0] sel_val_i,
    input  logic       gate_we_i,
    input  logic       gate_ext_val_i,
    input  logic       gate_lvl_val_i,
    input  logic       strobe_i,
    input  logic       tick_i,
    input  logic       ext_rise_i,
    input  logic       casc_rise_i,
    input  logic       ext_gate_i,
    output logic       ce_o,
    output logic       gate_o
);

    localparam bit HAS_CASC = (CH_IDX != 0);

    typedef struct packed {
        clk_src_e clk_sel;
        logic     gate_ext;
        logic     gate_lvl;
        logic     ce;
    } ch_st_t;

    ch_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ce = 1'b0;
        unique case (st_q.clk_sel)
            SRC_SW:   st_d.ce = strobe_i;
            SRC_TICK: st_d.ce = tick_i;
            SRC_EXT:  st_d.ce = ext_rise_i;
            SRC_CASC: st_d.ce = HAS_CASC && casc_rise_i;
            default:  st_d.ce = 1'b0;
        endcase
        if (sel_we_i) begin
            st_d.clk_sel = clk_src_e'(sel_val_i);
        end
        if (gate_we_i) begin
            st_d.gate_ext = gate_ext_val_i;
            st_d.gate_lvl = gate_lvl_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ce_o   = st_q.ce;
    assign gate_o = st_q.gate_ext ? ext_gate_i : st_q.gate_lvl;

    AST_SW_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.clk_sel == SRC_SW && strobe_i) |=> ce_o); // R3

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.clk_sel == SRC_TICK && tick_i) |=> ce_o); // R2

    AST_GATE_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_we_i && !gate_ext_val_i) |=> (gate_o == $past(gate_lvl_val_i))); // R7

    if (!HAS_CASC) begin : g_ch0
        AST_CH0_NO_CASC: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.clk_sel == SRC_CASC) |=> !ce_o); // R6
    end

endmodule

// File: rtl/ctr_irq_ctl.sv
module ctr_irq_ctl #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_we_i,
    input  logic [NUM_CH-1:0] en_val_i,
    input  logic [NUM_CH-1:0] clr_val_i,
    input  logic [NUM_CH-1:0] ctr_out_i,
    output logic              irq_o,
    output logic [NUM_CH-1:0] status_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] status;
        logic [NUM_CH-1:0] prev;
    } irq_st_t;

    irq_st_t           st_d, st_q;
    logic [NUM_CH-1:0] chg;
    logic [NUM_CH-1:0] clr;

    always_comb begin
        st_d      = st_q;
        chg       = (ctr_out_i ^ st_q.prev) & st_q.en;
        clr       = irq_we_i ? clr_val_i : '0;
        st_d.prev = ctr_out_i;
        if (irq_we_i) begin
            st_d.en = en_val_i;
        end
        st_d.status = (st_q.status & ~clr) | chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign irq_o    = |(st_q.status & st_q.en);

    AST_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != '0) |=> ((status_o & $past(chg)) == $past(chg))); // R9

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_we_i && (clr_val_i != '0)) |=>
            ((status_o & $past(status_o)) == $past(status_o))); // R10

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |-> !irq_o); // R11

endmodule

// File: rtl/ctr_route_irq.sv
module ctr_route_irq
    import ctr_route_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [2*NUM_CH-1:0]   wr_data,
    input  logic                  tick_i,
    input  logic                  ext_clk_i,
    input  logic                  ext_gate_i,
    input  logic [NUM_CH-1:0]     ctr_out_i,
    output logic [NUM_CH-1:0]     ctr_ce_o,
    output logic [NUM_CH-1:0]     ctr_gate_o,
    output logic                  irq_o,
    output logic [NUM_CH-1:0]     irq_status_o
);

    localparam int SYNC_W = 3;
    localparam int IDX_CLK  = 0;
    localparam int IDX_GATE = 1;
    localparam int IDX_CASC = 2;
    localparam logic [SYNC_W-1:0] EDGE_BITS = 3'b101;

    logic [SYNC_W-1:0] sync_in;
    logic [SYNC_W-1:0] sync_out;
    logic              we_sel, we_gate, we_strobe, we_irq;

    assign we_sel    = wr_en && (wr_addr == A_CLKSEL);
    assign we_gate   = wr_en && (wr_addr == A_GATE);
    assign we_strobe = wr_en && (wr_addr == A_STROBE);
    assign we_irq    = wr_en && (wr_addr == A_IRQ);

    assign sync_in[IDX_CLK]  = ext_clk_i;
    assign sync_in[IDX_GATE] = ext_gate_i;
    assign sync_in[IDX_CASC] = ctr_out_i[0];

    ctr_sync #(
        .WIDTH     (SYNC_W),
        .STAGES    (SYNC_STAGES),
        .EDGE_MASK (EDGE_BITS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din_i (sync_in),
        .out_o (sync_out)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ctr_ch_route #(
            .CH_IDX (c)
        ) u_ch (
            .clk            (clk),
            .rst_n          (rst_n),
            .sel_we_i       (we_sel),
            .sel_val_i      (wr_data[2*c +: 2]),
            .gate_we_i      (we_gate),
            .gate_ext_val_i (wr_data[c]),
            .gate_lvl_val_i (wr_data[NUM_CH+c]),
            .strobe_i       (we_strobe && wr_data[c]),
            .tick_i         (tick_i),
            .ext_rise_i     (sync_out[IDX_CLK]),
            .casc_rise_i    (sync_out[IDX_CASC]),
            .ext_gate_i     (sync_out[IDX_GATE]),
            .ce_o           (ctr_ce_o[c]),
            .gate_o         (ctr_gate_o[c])
        );
    end

    ctr_irq_ctl #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_we_i  (we_irq),
        .en_val_i  (wr_data[NUM_CH-1:0]),
        .clr_val_i (wr_data[2*NUM_CH-1:NUM_CH]),
        .ctr_out_i (ctr_out_i),
        .irq_o     (irq_o),
        .status_o  (irq_status_o)
    );

endmodule

// File: tb/sim_ctr_route_irq.sv
module sim_ctr_route_irq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic       tick_i = 1'b0;
    logic       ext_clk_i = 1'b0;
    logic       ext_gate_i = 1'b0;
    logic [2:0] ctr_out_i = '0;
    logic [2:0] ctr_ce_o, ctr_gate_o, irq_status_o;
    logic       irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    ctr_route_irq u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .tick_i       (tick_i),
        .ext_clk_i    (ext_clk_i),
        .ext_gate_i   (ext_gate_i),
        .ctr_out_i    (ctr_out_i),
        .ctr_ce_o     (ctr_ce_o),
        .ctr_gate_o   (ctr_gate_o),
        .irq_o        (irq_o),
        .irq_status_o (irq_status_o)
    );

    // fields: [12:7] clock sources {ch2,ch1,ch0}, [6:4] strobe bits, [3] tick, [2:0] expected enables
    localparam int NVEC = 8;
    localparam logic [12:0] VEC [NVEC] = '{
        13'b000000_111_0_111,
        13'b010101_111_1_111,
        13'b010101_000_0_000,
        13'b100100_001_1_011,
        13'b000001_100_0_100,
        13'b010011_111_1_110,
        13'b101010_111_1_000,
        13'b000000_010_1_010
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_ce(input int cycles, output int c0, output int c1, output int c2);
        c0 = 0; c1 = 0; c2 = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            c0 += int'(ctr_ce_o[0]);
            c1 += int'(ctr_ce_o[1]);
            c2 += int'(ctr_ce_o[2]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int p0, p1, p2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ce", ctr_ce_o, 3'b000);
        check("R1 gate", ctr_gate_o, 3'b000);
        check("R1 irq", irq_o, 1'b0);
        check("R1 status", irq_status_o, 3'b000);
        // R1 default source is software strobe
        wr(2'd2, 6'b000111);
        check("R1 default source software", ctr_ce_o, 3'b111);
        @(negedge clk);
        check("R3 single pulse", ctr_ce_o, 3'b000);

        // R2/R3 vector table
        for (int v = 0; v < NVEC; v++) begin
            wr(2'd0, VEC[v][12:7]);
            wr_en = 1'b1; wr_addr = 2'd2; wr_data = {3'b000, VEC[v][6:4]};
            tick_i = VEC[v][3];
            @(negedge clk);
            wr_en = 1'b0; tick_i = 1'b0;
            check($sformatf("R2 R3 vector %0d", v), ctr_ce_o, VEC[v][2:0]);
            @(negedge clk);
            check($sformatf("R3 vector %0d pulse ends", v), ctr_ce_o, 3'b000);
        end

        // R4 external clock: latency three edges, one pulse per rise
        wr(2'd0, 6'b101010);
        ext_clk_i = 1'b1;
        @(negedge clk);
        check("R4 edge1", ctr_ce_o, 3'b000);
        @(negedge clk);
        check("R4 edge2", ctr_ce_o, 3'b000);
        @(negedge clk);
        check("R4 edge3 pulse", ctr_ce_o, 3'b111);
        count_ce(8, p0, p1, p2);
        check("R4 held high no more pulses", p0 + p1 + p2, 0);
        ext_clk_i = 1'b0;
        repeat (4) @(negedge clk);
        ext_clk_i = 1'b1;
        count_ce(10, p0, p1, p2);
        check("R4 second rise one pulse", p0, 1);
        ext_clk_i = 1'b0;

        // R5 cascade from channel 0 output
        wr(2'd0, 6'b111100);
        ctr_out_i[0] = 1'b1;
        @(negedge clk);
        check("R5 edge1", ctr_ce_o, 3'b000);
        @(negedge clk);
        check("R5 edge2", ctr_ce_o, 3'b000);
        @(negedge clk);
        check("R5 cascade pulse", ctr_ce_o, 3'b110);
        count_ce(6, p0, p1, p2);
        check("R5 held high no more pulses", p1 + p2, 0);

        // R6 channel 0 on cascade code is silent
        wr(2'd0, 6'b000011);
        ctr_out_i[0] = 1'b0;
        repeat (4) @(negedge clk);
        ctr_out_i[0] = 1'b1;
        count_ce(8, p0, p1, p2);
        check("R6 ch0 cascade gives nothing", p0, 0);
        ctr_out_i[0] = 1'b0;

        // R7 gate register
        wr(2'd1, 6'b101_000);
        check("R7 software gate levels", ctr_gate_o, 3'b101);
        wr(2'd1, 6'b010_010);
        check("R7 external select ignores level", ctr_gate_o, 3'b000);

        // R8 external gate latency
        wr(2'd1, 6'b000_111);
        ext_gate_i = 1'b1;
        @(negedge clk);
        check("R8 edge1", ctr_gate_o, 3'b000);
        @(negedge clk);
        check("R8 edge2", ctr_gate_o, 3'b000);
        @(negedge clk);
        check("R8 edge3", ctr_gate_o, 3'b111);

        // R9 change detection
        ctr_out_i = 3'b000;
        repeat (2) @(negedge clk);
        ctr_out_i[0] = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 disabled change ignored", irq_status_o, 3'b000);
        wr(2'd3, 6'b000_011);
        check("R11 enabled no status no irq", irq_o, 1'b0);
        ctr_out_i[0] = 1'b0;
        @(negedge clk);
        check("R9 falling change sets", irq_status_o, 3'b001);
        check("R11 irq raised", irq_o, 1'b1);
        ctr_out_i[2] = 1'b1;
        @(negedge clk);
        check("R9 ch2 disabled", irq_status_o, 3'b001);
        repeat (3) @(negedge clk);
        check("R10 sticky", irq_status_o, 3'b001);

        // R10 clear and set-wins
        wr(2'd3, 6'b001_011);
        check("R10 cleared", irq_status_o, 3'b000);
        check("R11 irq low after clear", irq_o, 1'b0);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 6'b010_011;
        ctr_out_i[1] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 set wins over clear", irq_status_o, 3'b010);

        // R11 masking
        wr(2'd3, 6'b000_000);
        check("R11 status kept when disabled", irq_status_o, 3'b010);
        check("R11 irq masked", irq_o, 1'b0);
        wr(2'd3, 6'b000_010);
        check("R11 irq unmasked", irq_o, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule